// File: doc/BRIEF.md
# Wake-on-LAN Event Controller

This block handles everything that happens after a wake-frame detector has fired. A one-cycle detection pulse, accepted while wake mode is armed, latches three sticky status flags. These flags are a wake-match flag, a wake interrupt flag and a power-management status flag. From them the block drives a remote-wake pin, a power-management event pin, an interrupt line and a programmable LED. It also raises a hold signal that stalls the transmit and receive engines. Those engines keep their ring positions while stalled, so they continue where they stopped once the hold drops. No re-initialisation is needed.

The hold drops when the host signals that it is awake. The host does this either by asserting power-good or by clearing the mode enable bit. Leaving through power-good starts a guard interval: power-good must then stay low for at least 200 ns, counted in clock cycles, before a new detection is accepted. Leaving by clearing the enable bit re-arms as soon as the bit is set again. The block carries no data stream, so every pin is a plain level or strobe with no valid/ready handshake or back-pressure.

Top module: `wake_event_ctrl`

## Requirements
- R1: A detection pulse that is accepted sets the wake-match, wake interrupt and power-management status flags on the next clock edge. A pulse is accepted when the mode enable is 1, power-good is 0 and no guard interval is running.
- R2: The remote-wake output equals the wake-match flag.
- R3: The power-management event output is 1 only when the wake-match flag is 1 and at least one of the event enable bit and the event override bit is 1.
- R4: The interrupt output is 1 only when the wake interrupt flag is 1 and both the global interrupt enable and the wake interrupt enable are 1.
- R5: The LED's lit condition is the wake-match flag with the LED select bit at 1. With the polarity bit at 1 the output is high when lit; with it at 0 the output is low when lit. When not lit, the output sits at the opposite level.
- R6: An accepted detection asserts hold on the next edge. Hold stays asserted until power-good is 1 or the mode enable is 0 at an edge, and it then deasserts on that edge.
- R7: After power-good has been 1, detections stay ignored until power-good has been sampled 0 on GUARD_CYCLES consecutive edges. GUARD_CYCLES is 200 ns divided by the clock period and rounded up, which is 10 at the default 20 ns. A pulse on the edge after those samples is accepted.
- R8: Clearing the mode enable and setting it again re-arms at once. A pulse on the first edge with the enable back at 1 is accepted.
- R9: Each flag has its own write-1 clear strobe. A clear strobe at an edge clears its flag at that edge, and it wins over an accepted detection at the same edge.
- R10: A detection pulse is ignored while the mode enable is 0, while power-good is 1, or while the guard interval runs. An ignored pulse changes no flag and no hold.
- R11: A synchronous active-low reset clears all flags and the guard timer and deasserts hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| detect_i | input | 1 | One-cycle wake-frame detection pulse |
| mode_en_i | input | 1 | Wake mode enable |
| pwr_good_i | input | 1 | Power-good, active high |
| irq_en_i | input | 1 | Global interrupt enable |
| wake_irq_en_i | input | 1 | Wake interrupt enable |
| pme_en_i | input | 1 | Power-management event enable |
| pme_ovr_i | input | 1 | Power-management event enable override |
| led_sel_i | input | 1 | Route wake-match to the LED |
| led_pol_i | input | 1 | LED polarity: 1 active high, 0 active low |
| clr_match_i | input | 1 | Write-1 clear of the wake-match flag |
| clr_wint_i | input | 1 | Write-1 clear of the wake interrupt flag |
| clr_pms_i | input | 1 | Write-1 clear of the power-management status flag |
| match_flag_o | output | 1 | Wake-match sticky flag |
| wint_flag_o | output | 1 | Wake interrupt sticky flag |
| pms_flag_o | output | 1 | Power-management status sticky flag |
| irq_o | output | 1 | Interrupt line |
| rwake_o | output | 1 | Remote-wake pin |
| pme_o | output | 1 | Power-management event pin |
| led_o | output | 1 | LED output |
| hold_o | output | 1 | Stall for transmit and receive |

## Verification
The hardest condition to reach from the ports is the exact end of the guard interval. A detection has to land on the edge just before the last required low sample of power-good, and again on the edge just after it. Only then are both sides of the boundary seen. Random power-good activity almost never lines up this way, so directed sequences drive power-good low for exactly GUARD_CYCLES-1 and GUARD_CYCLES edges and then pulse detect. Constrained random traffic covers the mixing of clear strobes with detections and with hold release, and a bench reference model predicts every output.

// File: rtl/wol_pkg.sv
package wol_pkg;
  localparam int FLAG_CNT   = 3;
  localparam int FLAG_MATCH = 0;
  localparam int FLAG_WINT  = 1;
  localparam int FLAG_PMS   = 2;

  // guard length in cycles, rounded up, never below one cycle
  function automatic int guard_cycles(input int guard_ns, input int clk_ns);
    int c;
    c = (guard_ns + clk_ns - 1) / clk_ns;
    return (c < 1) ? 1 : c;
  endfunction
endpackage

// File: rtl/wol_sticky_flags.sv
module wol_sticky_flags #(
  parameter int N = 3
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         set_i,
  input  logic [N-1:0] clr_i,
  output logic [N-1:0] flag_o
);
  for (genvar g = 0; g < N; g++) begin : g_flag
    logic q;
    always_ff @(posedge clk) begin
      if (!rst_n)        q <= 1'b0;
      else if (clr_i[g]) q <= 1'b0;
      else if (set_i)    q <= 1'b1;
    end
    assign flag_o[g] = q;
  end
endmodule

// File: rtl/wol_rearm_guard.sv
module wol_rearm_guard #(
  parameter int GUARD_CYCLES = 10
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pwr_good_i,
  output logic busy_o
);
  localparam int CNT_W = $clog2(GUARD_CYCLES + 1);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(GUARD_CYCLES - 1);

  logic [CNT_W-1:0] cnt_q;
  logic             busy_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
    end else if (pwr_good_i) begin
      busy_q <= 1'b1;
      cnt_q  <= '0;
    end else if (busy_q) begin
      if (cnt_q == LAST) begin
        busy_q <= 1'b0;
        cnt_q  <= '0;
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  assign busy_o = busy_q;
endmodule

// File: rtl/wol_hold_ctrl.sv
module wol_hold_ctrl (
  input  logic clk,
  input  logic rst_n,
  input  logic accept_i,
  input  logic pwr_good_i,
  input  logic mode_en_i,
  output logic hold_o
);
  logic hold_q;
  always_ff @(posedge clk) begin
    if (!rst_n)                        hold_q <= 1'b0;
    else if (pwr_good_i || !mode_en_i) hold_q <= 1'b0;
    else if (accept_i)                 hold_q <= 1'b1;
  end
  assign hold_o = hold_q;
endmodule

// File: rtl/wol_pin_decode.sv
module wol_pin_decode (
  input  logic match_i,
  input  logic wint_i,
  input  logic irq_en_i,
  input  logic wake_irq_en_i,
  input  logic pme_en_i,
  input  logic pme_ovr_i,
  input  logic led_sel_i,
  input  logic led_pol_i,
  output logic irq_o,
  output logic rwake_o,
  output logic pme_o,
  output logic led_o
);
  logic lit;
  always_comb begin
    lit     = match_i & led_sel_i;
    rwake_o = match_i;
    pme_o   = match_i & (pme_en_i | pme_ovr_i);
    irq_o   = wint_i & irq_en_i & wake_irq_en_i;
    led_o   = led_pol_i ? lit : ~lit;
  end
endmodule

// File: rtl/wake_event_ctrl.sv
module wake_event_ctrl
  import wol_pkg::*;
#(
  parameter int CLK_PERIOD_NS = 20,
  parameter int GUARD_NS      = 200
) (
  input  logic clk,
  input  logic rst_n,
  input  logic detect_i,
  input  logic mode_en_i,
  input  logic pwr_good_i,
  input  logic irq_en_i,
  input  logic wake_irq_en_i,
  input  logic pme_en_i,
  input  logic pme_ovr_i,
  input  logic led_sel_i,
  input  logic led_pol_i,
  input  logic clr_match_i,
  input  logic clr_wint_i,
  input  logic clr_pms_i,
  output logic match_flag_o,
  output logic wint_flag_o,
  output logic pms_flag_o,
  output logic irq_o,
  output logic rwake_o,
  output logic pme_o,
  output logic led_o,
  output logic hold_o
);
  localparam int GUARD_CYCLES = guard_cycles(GUARD_NS, CLK_PERIOD_NS);

  logic                guard_busy;
  logic                accept;
  logic [FLAG_CNT-1:0] clr_vec;
  logic [FLAG_CNT-1:0] flags;

  assign accept = detect_i & mode_en_i & ~pwr_good_i & ~guard_busy;

  always_comb begin
    clr_vec             = '0;
    clr_vec[FLAG_MATCH] = clr_match_i;
    clr_vec[FLAG_WINT]  = clr_wint_i;
    clr_vec[FLAG_PMS]   = clr_pms_i;
  end

  wol_rearm_guard #(.GUARD_CYCLES(GUARD_CYCLES)) i_guard (
    .clk(clk), .rst_n(rst_n), .pwr_good_i(pwr_good_i), .busy_o(guard_busy)
  );

  wol_sticky_flags #(.N(FLAG_CNT)) i_flags (
    .clk(clk), .rst_n(rst_n), .set_i(accept), .clr_i(clr_vec), .flag_o(flags)
  );

  wol_hold_ctrl i_hold (
    .clk(clk), .rst_n(rst_n), .accept_i(accept), .pwr_good_i(pwr_good_i),
    .mode_en_i(mode_en_i), .hold_o(hold_o)
  );

  assign match_flag_o = flags[FLAG_MATCH];
  assign wint_flag_o  = flags[FLAG_WINT];
  assign pms_flag_o   = flags[FLAG_PMS];

  wol_pin_decode i_pins (
    .match_i(match_flag_o), .wint_i(wint_flag_o),
    .irq_en_i(irq_en_i), .wake_irq_en_i(wake_irq_en_i),
    .pme_en_i(pme_en_i), .pme_ovr_i(pme_ovr_i),
    .led_sel_i(led_sel_i), .led_pol_i(led_pol_i),
    .irq_o(irq_o), .rwake_o(rwake_o), .pme_o(pme_o), .led_o(led_o)
  );
endmodule

// File: rtl/wake_event_checker.sv
module wake_event_checker (
  input logic clk,
  input logic rst_n,
  input logic detect_i,
  input logic mode_en_i,
  input logic pwr_good_i,
  input logic clr_match_i,
  input logic clr_wint_i,
  input logic clr_pms_i,
  input logic match_flag_o,
  input logic wint_flag_o,
  input logic pms_flag_o,
  input logic irq_o,
  input logic pme_o,
  input logic hold_o,
  input logic guard_busy
);
  a_r1_flags_set: assert property (@(posedge clk) disable iff (!rst_n)
    (detect_i && mode_en_i && !pwr_good_i && !guard_busy && !clr_match_i && !clr_wint_i && !clr_pms_i)
    |=> (match_flag_o && wint_flag_o && pms_flag_o));

  a_r9_clear_wins: assert property (@(posedge clk) disable iff (!rst_n)
    clr_match_i |=> !match_flag_o);

  a_r6_hold_on_detect: assert property (@(posedge clk) disable iff (!rst_n)
    (detect_i && mode_en_i && !pwr_good_i && !guard_busy) |=> hold_o);

  a_r6_hold_release: assert property (@(posedge clk) disable iff (!rst_n)
    (pwr_good_i || !mode_en_i) |=> !hold_o);

  a_r10_ignored_when_off: assert property (@(posedge clk) disable iff (!rst_n)
    (!mode_en_i && !match_flag_o) |=> !match_flag_o);

  a_r10_ignored_in_guard: assert property (@(posedge clk) disable iff (!rst_n)
    (guard_busy && !hold_o) |=> !hold_o);

  a_r7_guard_starts: assert property (@(posedge clk) disable iff (!rst_n)
    pwr_good_i |=> guard_busy);

  a_r4_irq_needs_flag: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |-> wint_flag_o);

  a_r3_pme_needs_flag: assert property (@(posedge clk) disable iff (!rst_n)
    pme_o |-> match_flag_o);
endmodule

bind wake_event_ctrl wake_event_checker i_chk (
  .clk(clk), .rst_n(rst_n), .detect_i(detect_i), .mode_en_i(mode_en_i),
  .pwr_good_i(pwr_good_i), .clr_match_i(clr_match_i), .clr_wint_i(clr_wint_i),
  .clr_pms_i(clr_pms_i), .match_flag_o(match_flag_o), .wint_flag_o(wint_flag_o),
  .pms_flag_o(pms_flag_o), .irq_o(irq_o), .pme_o(pme_o), .hold_o(hold_o),
  .guard_busy(guard_busy)
);

// File: tb/test_wake_event_ctrl.sv
`timescale 1ns/1ps
module test_wake_event_ctrl;
  localparam int CLK_NS = 20;
  localparam int GUARD  = (200 + CLK_NS - 1) / CLK_NS;

  logic clk = 1'b0;
  logic rst_n, detect, men, pg, ien, wien, pen, povr, lsel, lpol, cm, cw, cp;
  logic match_f, wint_f, pms_f, irq, rwake, pme, led, hold;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  // reference model state
  bit m_match, m_wint, m_pms, m_hold, m_wait;
  int m_cnt;

  always #(CLK_NS/2) clk = ~clk;

  wake_event_ctrl #(.CLK_PERIOD_NS(CLK_NS), .GUARD_NS(200)) i_wake_event_ctrl (
    .clk(clk), .rst_n(rst_n), .detect_i(detect), .mode_en_i(men), .pwr_good_i(pg),
    .irq_en_i(ien), .wake_irq_en_i(wien), .pme_en_i(pen), .pme_ovr_i(povr),
    .led_sel_i(lsel), .led_pol_i(lpol), .clr_match_i(cm), .clr_wint_i(cw),
    .clr_pms_i(cp), .match_flag_o(match_f), .wint_flag_o(wint_f), .pms_flag_o(pms_f),
    .irq_o(irq), .rwake_o(rwake), .pme_o(pme), .led_o(led), .hold_o(hold)
  );

  task automatic chk(input logic act, input logic exp, input string req);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%b expected=%b at %0t", req, act, exp, $time);
    end
  endtask

  function automatic bit exp_led(bit m, bit sel, bit pol);
    bit lit;
    lit = m & sel;
    return pol ? lit : ~lit;
  endfunction

  // compare outputs against the model for the current inputs
  task automatic compare();
    chk(match_f, m_match, "R1 match flag");
    chk(wint_f,  m_wint,  "R1 wint flag");
    chk(pms_f,   m_pms,   "R1 pms flag");
    chk(rwake,   m_match, "R2 remote wake");
    chk(pme,     m_match & (pen | povr), "R3 pme");
    chk(irq,     m_wint & ien & wien, "R4 irq");
    chk(led,     exp_led(m_match, lsel, lpol), "R5 led");
    chk(hold,    m_hold, "R6 hold");
  endtask

  // advance model by one edge using current inputs
  task automatic model_edge();
    bit acc;
    acc = detect & men & ~pg & ~m_wait;
    if (!rst_n) begin
      m_match = 0; m_wint = 0; m_pms = 0; m_hold = 0; m_wait = 0; m_cnt = 0;
      return;
    end
    m_match = cm ? 1'b0 : (acc ? 1'b1 : m_match);
    m_wint  = cw ? 1'b0 : (acc ? 1'b1 : m_wint);
    m_pms   = cp ? 1'b0 : (acc ? 1'b1 : m_pms);
    if (pg || !men) m_hold = 0;
    else if (acc)   m_hold = 1;
    if (pg) begin m_wait = 1; m_cnt = 0; end
    else if (m_wait) begin
      if (m_cnt == GUARD - 1) begin m_wait = 0; m_cnt = 0; end
      else m_cnt++;
    end
  endtask

  // inputs are already set at a negedge: check, then pass one edge
  task automatic step();
    #1;
    compare();
    model_edge();
    @(negedge clk);
  endtask

  task automatic quiet();
    detect = 0; cm = 0; cw = 0; cp = 0;
  endtask

  initial begin
    #(200000 * CLK_NS);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    rst_n = 0; detect = 0; men = 1; pg = 0; ien = 1; wien = 1; pen = 1; povr = 0;
    lsel = 1; lpol = 1; cm = 0; cw = 0; cp = 0;
    m_match = 0; m_wint = 0; m_pms = 0; m_hold = 0; m_wait = 0; m_cnt = 0;
    @(negedge clk);
    step(); step();
    // R11: reset state
    chk(match_f | wint_f | pms_f, 1'b0, "R11 flags after reset");
    chk(hold, 1'b0, "R11 hold after reset");
    rst_n = 1;
    step();

    // R1/R6: accepted detection
    detect = 1; step(); quiet();
    #1;
    chk(match_f & wint_f & pms_f, 1'b1, "R1 all flags set");
    chk(hold, 1'b1, "R6 hold after detect");
    step(); step();
    // R9: clear wins over simultaneous detection
    detect = 1; cm = 1; step(); quiet(); #1;
    chk(match_f, 1'b0, "R9 clear beats detect");
    chk(wint_f, 1'b1, "R9 other flag kept");
    cw = 1; cp = 1; step(); quiet();
    // R6: release by power-good
    pg = 1; step(); #1;
    chk(hold, 1'b0, "R6 released by power-good");
    // R7: GUARD-1 low samples, then detect ignored
    pg = 0;
    for (int i = 0; i < GUARD - 1; i++) step();
    detect = 1; step(); quiet(); #1;
    chk(match_f, 1'b0, "R7 detect inside guard ignored");
    chk(hold, 1'b0, "R10 no hold inside guard");
    // R7: exactly GUARD low samples, then accepted
    pg = 1; step(); pg = 0;
    for (int i = 0; i < GUARD; i++) step();
    detect = 1; step(); quiet(); #1;
    chk(match_f, 1'b1, "R7 detect after guard accepted");
    cm = 1; cw = 1; cp = 1; step(); quiet();
    // R8: clear enable, set again, immediate re-arm
    men = 0; step(); #1;
    chk(hold, 1'b0, "R6 released by enable clear");
    detect = 1; step(); quiet(); #1;
    chk(match_f, 1'b0, "R10 ignored while disabled");
    men = 1; detect = 1; step(); quiet(); #1;
    chk(match_f, 1'b1, "R8 immediate re-arm");
    // R10: detect with power-good high ignored
    cm = 1; cw = 1; cp = 1; step(); quiet();
    pg = 1; detect = 1; step(); quiet(); pg = 0; #1;
    chk(match_f, 1'b0, "R10 ignored with power-good high");
    // R5: LED polarities with flag set and clear
    for (int i = 0; i < GUARD + 1; i++) step();
    detect = 1; step(); quiet();
    lsel = 1; lpol = 0; #1; chk(led, 1'b0, "R5 active-low lit");
    lsel = 0; #1; chk(led, 1'b1, "R5 active-low unlit");
    lpol = 1; #1; chk(led, 1'b0, "R5 active-high unlit");
    step();

    // constrained random traffic
    for (int n = 0; n < 4000; n++) begin
      detect = ($urandom_range(7) == 0);
      men    = ($urandom_range(15) != 0);
      pg     = ($urandom_range(23) == 0);
      ien    = $urandom_range(1); wien = $urandom_range(1);
      pen    = $urandom_range(1); povr = $urandom_range(1);
      lsel   = $urandom_range(1); lpol = $urandom_range(1);
      cm     = ($urandom_range(9) == 0);
      cw     = ($urandom_range(9) == 0);
      cp     = ($urandom_range(9) == 0);
      rst_n  = ($urandom_range(499) != 0);
      step();
    end
    rst_n = 1; quiet(); step();

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule